// File: doc/BRIEF.md
# Switchable-Latency SRAM Read Output Stage

This block sits between a synchronous SRAM array and its data pins. A command front-end gives it one cycle type per clock: deselect, read or write. The array gives it read data during the access cycle. The block decides in which cycle read data is placed on the data bus, and when the bus is released. A run-time mode input selects the latency. In flow-through timing, read data passes straight from the array to the bus in the access cycle. In pipelined timing, the data first goes through one rising-edge output register. A registered deselect or write releases the bus in the next cycle in both modes, which is one stage sooner than pipelined read data appears. An active-low output enable gates the drivers combinationally.

The bus is modelled as a data vector plus a drive-enable flag. When the drivers are off, the data vector is held at zero. The block also handles sleep:

- A sleep request that is held for two clock edges puts the block to sleep. While asleep it ignores commands and releases the bus.
- After waking, a programmable recovery window follows. During that window writes are refused and a sticky error flag records the attempt. Reads and deselects are accepted during the window.
- Accepted writes are passed on to the array as a write strobe with byte enables.

Top module: `sram_rd_out_stage`

## Requirements
- R1: With `pipe_mode_i` low, a read registered at edge k drives `dq_oe_o` high and `dq_o` equal to `rd_data_i` during the cycle that follows edge k.
- R2: With `pipe_mode_i` high, the array data of a read registered at edge k is driven during the cycle after edge k+1, provided a read is also registered at edge k+1.
- R3: With `pipe_mode_i` high, a deselect registered at edge k+1 after a read at edge k keeps the bus released in the cycle after edge k+1. Cycle code 2'b00 is deselect; 2'b11 is also treated as deselect.
- R4: In the cycle after a write is registered, the bus is released in both modes. Cycle code 2'b10 is write.
- R5: `oe_ni` high releases the bus at once. `oe_ni` low never enables the bus unless a read is being driven. Cycle code 2'b01 is read.
- R6: `dq_o` is all zeros whenever `dq_oe_o` is low.
- R7: During a driven read, every byte lane carries array data, whatever the value of `be_i`.
- R8: `sleep_i` sampled high at two consecutive edges sets `sleep_o` after the second edge. Commands at that second edge are still accepted. While asleep, later commands are ignored, so there is no write strobe and the bus stays released.
- R9: The edge at which `sleep_i` is sampled low while asleep clears `sleep_o` and ignores that edge's command. During the next REC_CYC edges, writes are refused and reads are accepted.
- R10: A write refused during recovery sets `rec_err_o`, which stays high until reset.
- R11: An accepted write raises `wr_en_o` for the cycle after its edge, with `wr_be_o` equal to the registered `be_i`. `wr_be_o` is zero otherwise.
- R12: During reset, `dq_oe_o`, `dq_o`, `wr_en_o`, `wr_be_o`, `sleep_o` and `rec_err_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pipe_mode_i | input | 1 | 1 = pipelined latency, 0 = flow-through |
| oe_ni | input | 1 | Output enable, active low, combinational |
| sleep_i | input | 1 | Sleep request, active high |
| cyc_i | input | 2 | Cycle type: 00 deselect, 01 read, 10 write, 11 deselect |
| be_i | input | LANES | Byte-lane write enables for the current cycle |
| rd_data_i | input | LANES*LANE_W | Array read data, valid in the access cycle |
| dq_o | output | LANES*LANE_W | Bus data, zero when not driven |
| dq_oe_o | output | 1 | Bus drive enable |
| wr_en_o | output | 1 | Accepted write strobe to the array |
| wr_be_o | output | LANES | Byte enables of the accepted write |
| sleep_o | output | 1 | Block is asleep |
| rec_err_o | output | 1 | Sticky: a write arrived during recovery |

## Verification
The hardest state to reach is the end of the recovery window. At that point a write at the last blocked edge must be refused, and a write one edge later must be accepted. The only way in is a full sleep round trip: two edges with the sleep request high, some ignored commands while asleep, and a wake edge that itself ignores its command. The bench walks this sequence with directed steps. It places writes on the first and last recovery edges and on the first free edge, and a read between them. It then checks that the error flag survives until the next reset.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  typedef enum logic [1:0] {
    CYC_DESEL = 2'b00,
    CYC_READ  = 2'b01,
    CYC_WRITE = 2'b10,
    CYC_RSVD  = 2'b11
  } cyc_e;
endpackage

// File: rtl/rdo_sleep_ctl.sv
module rdo_sleep_ctl
  import rdo_pkg::*;
#(
  parameter int unsigned REC_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_i,
  input  logic [1:0] cyc_i,
  output cyc_e       cyc_acc_o,
  output logic       asleep_o,
  output logic       rec_err_o
);
  localparam int unsigned RW = $clog2(REC_CYC + 1);

  logic          seen_q, asleep_q, err_q;
  logic [RW-1:0] rec_q;
  logic          rec_act, blocked;

  assign rec_act = (rec_q != '0);
  assign blocked = !asleep_q && rec_act && (cyc_i == CYC_WRITE);

  always_comb begin
    if (asleep_q || blocked || cyc_i == CYC_RSVD) cyc_acc_o = CYC_DESEL;
    else                                          cyc_acc_o = cyc_e'(cyc_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q   <= 1'b0;
      asleep_q <= 1'b0;
      rec_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= err_q | blocked;
      if (sleep_i) begin
        seen_q <= 1'b1;
        if (seen_q) asleep_q <= 1'b1;
        if (rec_act) rec_q <= rec_q - 1'b1;
      end else begin
        seen_q <= 1'b0;
        if (asleep_q) begin
          asleep_q <= 1'b0;
          rec_q    <= RW'(REC_CYC);
        end else if (rec_act) begin
          rec_q <= rec_q - 1'b1;
        end
      end
    end
  end

  assign asleep_o  = asleep_q;
  assign rec_err_o = err_q;

  AST_REC_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_act && cyc_i == CYC_WRITE |-> cyc_acc_o != CYC_WRITE); // R9
  AST_REC_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_act && !asleep_q && cyc_i == CYC_WRITE |=> rec_err_o); // R10
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rec_err_o) |-> rec_err_o); // R10
  AST_WAKE_RECOVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asleep_o && !sleep_i |=> !asleep_o && rec_act); // R9
endmodule

// File: rtl/rdo_cmd_pipe.sv
module rdo_cmd_pipe
  import rdo_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  cyc_e                    cyc_acc_i,
  input  logic [LANES-1:0]        be_i,
  input  logic [LANES*LANE_W-1:0] rd_data_i,
  output logic                    s1_rd_o,
  output logic                    s1_wr_o,
  output logic [LANES-1:0]        s1_be_o,
  output logic                    s2_rd_o,
  output logic [LANES*LANE_W-1:0] s2_data_o
);
  localparam int unsigned DW = LANES * LANE_W;

  cyc_e             s1_q;
  logic [LANES-1:0] be_q;
  logic             s2_q;
  logic [DW-1:0]    data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= CYC_DESEL;
      be_q   <= '0;
      s2_q   <= 1'b0;
      data_q <= '0;
    end else begin
      s1_q <= cyc_acc_i;
      be_q <= (cyc_acc_i == CYC_WRITE) ? be_i : '0;
      s2_q <= (s1_q == CYC_READ);
      if (s1_q == CYC_READ) data_q <= rd_data_i;
    end
  end

  assign s1_rd_o   = (s1_q == CYC_READ);
  assign s1_wr_o   = (s1_q == CYC_WRITE);
  assign s1_be_o   = be_q;
  assign s2_rd_o   = s2_q;
  assign s2_data_o = data_q;
endmodule

// File: rtl/rdo_out_gate.sv
module rdo_out_gate #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pipe_mode_i,
  input  logic                    oe_ni,
  input  logic                    asleep_i,
  input  logic                    s1_rd_i,
  input  logic                    s2_rd_i,
  input  logic [LANES*LANE_W-1:0] s2_data_i,
  input  logic [LANES*LANE_W-1:0] rd_data_i,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_oe_o
);
  localparam int unsigned DW = LANES * LANE_W;

  logic          drv;
  logic [DW-1:0] src;

  // deselect/write in stage 1 kills pipelined data one stage early
  assign drv     = pipe_mode_i ? (s2_rd_i & s1_rd_i) : s1_rd_i;
  assign src     = pipe_mode_i ? s2_data_i : rd_data_i;
  assign dq_oe_o = drv & ~asleep_i & ~oe_ni;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dq_o[g*LANE_W +: LANE_W] = dq_oe_o ? src[g*LANE_W +: LANE_W] : '0;
  end

  AST_QUIET_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_oe_o |-> dq_o == '0); // R6
  AST_PIPE_NEEDS_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pipe_mode_i && dq_oe_o |-> $past(s1_rd_i)); // R2
endmodule

// File: rtl/sram_rd_out_stage.sv
module sram_rd_out_stage
  import rdo_pkg::*;
#(
  parameter int unsigned LANES   = 4,
  parameter int unsigned LANE_W  = 9,
  parameter int unsigned REC_CYC = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pipe_mode_i,
  input  logic                    oe_ni,
  input  logic                    sleep_i,
  input  logic [1:0]              cyc_i,
  input  logic [LANES-1:0]        be_i,
  input  logic [LANES*LANE_W-1:0] rd_data_i,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_oe_o,
  output logic                    wr_en_o,
  output logic [LANES-1:0]        wr_be_o,
  output logic                    sleep_o,
  output logic                    rec_err_o
);
  localparam int unsigned DW = LANES * LANE_W;

  cyc_e          cyc_acc;
  logic          asleep, s1_rd, s1_wr, s2_rd;
  logic [DW-1:0] s2_data;

  rdo_sleep_ctl #(.REC_CYC(REC_CYC)) u_sleep (
    .clk_i, .rst_ni, .sleep_i, .cyc_i,
    .cyc_acc_o(cyc_acc), .asleep_o(asleep), .rec_err_o
  );

  rdo_cmd_pipe #(.LANES(LANES), .LANE_W(LANE_W)) u_pipe (
    .clk_i, .rst_ni, .cyc_acc_i(cyc_acc), .be_i, .rd_data_i,
    .s1_rd_o(s1_rd), .s1_wr_o(s1_wr), .s1_be_o(wr_be_o),
    .s2_rd_o(s2_rd), .s2_data_o(s2_data)
  );

  rdo_out_gate #(.LANES(LANES), .LANE_W(LANE_W)) u_gate (
    .clk_i, .rst_ni, .pipe_mode_i, .oe_ni, .asleep_i(asleep),
    .s1_rd_i(s1_rd), .s2_rd_i(s2_rd), .s2_data_i(s2_data),
    .rd_data_i, .dq_o, .dq_oe_o
  );

  assign wr_en_o = s1_wr;
  assign sleep_o = asleep;

  AST_WRITE_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !dq_oe_o); // R4
  AST_OE_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !dq_oe_o); // R5
  AST_SLEEP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o && $past(sleep_o) |-> !wr_en_o && !dq_oe_o); // R8
  AST_BE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_o |-> wr_be_o == '0); // R11
endmodule

// File: tb/sram_rd_out_stage_tb.sv
module sram_rd_out_stage_tb;
  localparam int unsigned LANES = 4, LANE_W = 9, DW = 36, REC = 3;
  localparam logic [1:0] DS = 2'b00, RD = 2'b01, WR = 2'b10;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic pipe_mode_i = 1'b0, oe_ni = 1'b0, sleep_i = 1'b0;
  logic [1:0] cyc_i = DS;
  logic [LANES-1:0] be_i = '0;
  logic [DW-1:0] rd_data_i = '0;
  logic [DW-1:0] dq_o;
  logic dq_oe_o, wr_en_o, sleep_o, rec_err_o;
  logic [LANES-1:0] wr_be_o;
  int checks = 0, fails = 0;

  always #4 clk_i = ~clk_i;

  sram_rd_out_stage #(.LANES(LANES), .LANE_W(LANE_W), .REC_CYC(REC)) u_dut (.*);

  typedef struct packed {
    logic md; logic on; logic [1:0] c; logic [3:0] b; logic [35:0] d;
    logic xoe; logic [35:0] xdq; logic xwr; logic [3:0] xbe;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{1'b0,1'b0,RD,4'h0,36'h111111111, 1'b1,36'h111111111,1'b0,4'h0}, // R1
    '{1'b0,1'b0,RD,4'hF,36'h222222222, 1'b1,36'h222222222,1'b0,4'h0}, // R7
    '{1'b0,1'b0,WR,4'h5,36'hFFFFFFFFF, 1'b0,36'h0,1'b1,4'h5},         // R4 R11
    '{1'b0,1'b0,DS,4'h0,36'h333333333, 1'b0,36'h0,1'b0,4'h0},
    '{1'b1,1'b0,RD,4'h0,36'h444444444, 1'b0,36'h0,1'b0,4'h0},         // R2 fill
    '{1'b1,1'b0,RD,4'h0,36'h555555555, 1'b1,36'h444444444,1'b0,4'h0}, // R2
    '{1'b1,1'b0,RD,4'h3,36'h666666666, 1'b1,36'h555555555,1'b0,4'h0}, // R7
    '{1'b1,1'b0,DS,4'h0,36'h777777777, 1'b0,36'h0,1'b0,4'h0},         // R3
    '{1'b1,1'b0,RD,4'h0,36'h888888888, 1'b0,36'h0,1'b0,4'h0},
    '{1'b1,1'b1,RD,4'h0,36'h999999999, 1'b0,36'h0,1'b0,4'h0},         // R5
    '{1'b1,1'b0,WR,4'h3,36'hAAAAAAAAA, 1'b0,36'h0,1'b1,4'h3},         // R4
    '{1'b0,1'b0,2'b11,4'h0,36'hBBBBBBBBB,1'b0,36'h0,1'b0,4'h0},       // R5 R3
    '{1'b0,1'b0,RD,4'h0,36'hCCCCCCCCC, 1'b1,36'hCCCCCCCCC,1'b0,4'h0}  // R1
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic md, input logic on, input logic [1:0] c,
                      input logic [3:0] b, input logic sl, input logic [35:0] d);
    @(negedge clk_i);
    pipe_mode_i = md; oe_ni = on; cyc_i = c; be_i = b; sleep_i = sl;
    @(posedge clk_i);
    #1 rd_data_i = d;
    #2;
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R12 oe", 64'(dq_oe_o), 64'd0);
    chk("R12 dq", 64'(dq_o), 64'd0);
    chk("R12 wr", 64'({wr_en_o, wr_be_o, sleep_o, rec_err_o}), 64'd0);
    @(negedge clk_i) rst_ni = 1'b1;

    foreach (VECS[i]) begin
      step(VECS[i].md, VECS[i].on, VECS[i].c, VECS[i].b, 1'b0, VECS[i].d);
      chk($sformatf("R1/R2/R3/R4/R5 oe row%0d", i), 64'(dq_oe_o), 64'(VECS[i].xoe));
      chk($sformatf("R6/R7 dq row%0d", i), 64'(dq_o), 64'(VECS[i].xdq));
      chk($sformatf("R11 wr row%0d", i), 64'({wr_en_o, wr_be_o}), 64'({VECS[i].xwr, VECS[i].xbe}));
    end

    // sleep entry
    step(1'b0, 1'b0, RD, 4'h0, 1'b1, 36'h123456789);
    chk("R8 not yet asleep", 64'(sleep_o), 64'd0);
    chk("R8 read before sleep", 64'(dq_o), 64'h123456789);
    step(1'b0, 1'b0, WR, 4'hF, 1'b1, 36'h0);
    chk("R8 asleep after two edges", 64'(sleep_o), 64'd1);
    chk("R8 write at second edge kept", 64'(wr_en_o), 64'd1);
    step(1'b0, 1'b0, RD, 4'h0, 1'b1, 36'h0ABCDEF01);
    chk("R8 read ignored", 64'(dq_oe_o), 64'd0);
    step(1'b0, 1'b0, WR, 4'hF, 1'b1, 36'h0);
    chk("R8 write ignored", 64'(wr_en_o), 64'd0);
    // wake and recovery
    step(1'b0, 1'b0, RD, 4'h0, 1'b0, 36'h0DEADBEEF);
    chk("R9 wake edge clears sleep", 64'(sleep_o), 64'd0);
    chk("R9 wake edge command ignored", 64'(dq_oe_o), 64'd0);
    step(1'b0, 1'b0, WR, 4'hF, 1'b0, 36'h0);
    chk("R9 first recovery write refused", 64'(wr_en_o), 64'd0);
    chk("R10 error raised", 64'(rec_err_o), 64'd1);
    step(1'b0, 1'b0, RD, 4'h0, 1'b0, 36'h0CAFEF00D);
    chk("R9 read during recovery", 64'(dq_o), 64'h0CAFEF00D);
    step(1'b0, 1'b0, WR, 4'h6, 1'b0, 36'h0);
    chk("R9 last recovery write refused", 64'(wr_en_o), 64'd0);
    step(1'b0, 1'b0, WR, 4'hA, 1'b0, 36'h0);
    chk("R9 write after recovery", 64'({wr_en_o, wr_be_o}), 64'h1A);
    step(1'b0, 1'b0, DS, 4'h0, 1'b0, 36'h0);
    chk("R10 error sticky", 64'(rec_err_o), 64'd1);

    @(negedge clk_i) rst_ni = 1'b0;
    #1 chk("R10 R12 error cleared by reset", 64'(rec_err_o), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule